// File: doc/BRIEF.md
# Video Clamp Pulse Timing Generator

This block decides, once per video line, when the black-level restore circuit of a three-channel video digitizer may connect to the input. It runs on the pixel clock. In its internal mode it waits for the end of horizontal sync, counts a programmable number of pixel periods so the signal can settle on the back porch, and then holds an active-high clamp strobe for a programmable number of pixel periods. The end of sync is used as the reference because sync width varies between video modes, while the back porch always follows it.

An external mode hands the strobe over to a clamp input pin whose active level is selectable. For each of the three channels a select bit picks the level the channel is restored to: ground (code 00h) for component signals whose black sits at the bottom of the range, or midscale (code 80h) for colour-difference signals whose reference sits in the middle. The package holds the recommended register-bus reset values for the settle and strobe lengths (9 and 20 pixel periods).

Top module: `clamp_pulse_gen`

## Requirements
- R1: The sync input is normalized with `cfg_sync_pol` (0: sync active high, 1: sync active low). A trailing edge is the clock edge at which normalized sync is sampled inactive after being sampled active at the previous edge; both polarities produce exactly one such edge per sync pulse.
- R2: In internal mode (`cfg_ext_mode`=0), with trailing edge at clock edge T, settle length P=`cfg_settle` and strobe length D=`cfg_width` sampled at T, `clamp_o` is 1 after edges T+P through T+P+D-1 and 0 after every other edge of that line; P=0 asserts the strobe right after edge T.
- R3: A strobe length of 0 produces no strobe on that line for any settle length.
- R4: A trailing edge that arrives while the settle or strobe count of an earlier line is running drops that count and starts a new line from the settle phase.
- R5: `cfg_settle`, `cfg_width` and `cfg_mid_sel` are used only as sampled at a trailing edge; changing them between trailing edges has no effect on the running line or on the target outputs.
- R6: When `cfg_ext_mode` is 1, `clamp_o` equals the external input after polarity correction, one clock later: with `cfg_ext_pol`=1 the input is active high, with 0 active low. Mode and polarity take effect at the next clock edge, not at a trailing edge.
- R7: Bit i of `cfg_mid_sel` (i = 0, 1, 2), captured at a trailing edge, sets `tgt_mid_o[i]`; lane i of `tgt_code_o` (bits 8i+7..8i) is 80h when that bit is 1 and 00h when it is 0.
- R8: While `rst_n` is low at a clock edge, after that edge `clamp_o` is 0, `tgt_mid_o` is 000 and `tgt_code_o` is all zero, and no line is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync from the video source |
| ext_clamp_in | input | 1 | External clamp request |
| cfg_settle | input | 8 | Pixel periods between sync trailing edge and strobe |
| cfg_width | input | 8 | Pixel periods the strobe stays high |
| cfg_ext_mode | input | 1 | 1: strobe follows the external input |
| cfg_ext_pol | input | 1 | 1: external input active high, 0: active low |
| cfg_sync_pol | input | 1 | 1: sync active low, 0: active high |
| cfg_mid_sel | input | 3 | Per-channel target select, 1 = midscale |
| clamp_o | output | 1 | Active-high clamp strobe |
| tgt_mid_o | output | 3 | Per-channel target is midscale |
| tgt_code_o | output | 24 | Per-channel target code, 8 bits per lane, channel 0 in the low lane |

## Verification
The embedded assertions watch, every cycle, that a trailing edge lasts one cycle, that a zero strobe length and a restart leave the strobe low on the next cycle, that a zero settle length raises it at once, that the external path tracks its pin one clock later, and that the target selects never move between trailing edges. The exact placement and length of each strobe, the restart of a half-finished line, the isolation of a running line from mid-line configuration changes, and the active-low sync path can only be shown by the bench's line sequences compared with its own timing model.

// File: rtl/clamp_pkg.sv
// Package: shared types and recommended reset values for the clamp generator.
// Assumes 8-bit counts and codes at the default parameters.
package clamp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_CLAMP  = 2'd2
    } clamp_phase_e;

    // Recommended register-bus reset values: 9 settle periods, 20 strobe periods.
    localparam int unsigned SETTLE_DEFAULT = 9;
    localparam int unsigned WIDTH_DEFAULT  = 20;

endpackage

// File: rtl/clamp_sync_edge.sv
// Module: clamp_sync_edge
// Normalizes the sync input to active high and flags the clock edge at which
// it is first seen inactive after being active (trailing edge).
// Assumes sync is already synchronous to the pixel clock.
module clamp_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic sync_pol,
    output logic trail_o
);

    logic sync_act;
    logic sync_d;

    // Polarity correction: pol=1 means sync is active low.
    assign sync_act = sync_in ^ sync_pol;

    // Remember last sampled normalized sync level.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_d <= 1'b0;
        else        sync_d <= sync_act;
    end

    // Trailing edge: active last cycle, inactive now.
    assign trail_o = sync_d & ~sync_act;

    AST_TRAIL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trail_o |=> !trail_o); // R1

endmodule

// File: rtl/clamp_window_fsm.sv
// Module: clamp_window_fsm
// Times the internal clamp window: settle phase of P cycles, then strobe of
// D cycles, both counted from the start pulse. A start pulse at any time
// restarts from the settle phase. Assumes start is a single-cycle pulse.
module clamp_window_fsm
    import clamp_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] settle_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             win_o
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    clamp_phase_e     phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] width_q;

    // Phase and down-counter; a start pulse overrides whatever is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= CNT_ZERO;
            width_q <= CNT_W'(WIDTH_DEFAULT);
        end else if (start_i) begin
            width_q <= width_i;
            if (settle_i != CNT_ZERO) begin
                phase <= PH_SETTLE;
                cnt   <= settle_i - CNT_ONE;
            end else if (width_i != CNT_ZERO) begin
                phase <= PH_CLAMP;
                cnt   <= width_i - CNT_ONE;
            end else begin
                phase <= PH_IDLE;
                cnt   <= CNT_ZERO;
            end
        end else begin
            case (phase)
                PH_SETTLE: begin
                    if (cnt != CNT_ZERO) begin
                        cnt <= cnt - CNT_ONE;
                    end else if (width_q != CNT_ZERO) begin
                        phase <= PH_CLAMP;
                        cnt   <= width_q - CNT_ONE;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end
                PH_CLAMP: begin
                    if (cnt != CNT_ZERO) cnt <= cnt - CNT_ONE;
                    else                 phase <= PH_IDLE;
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= CNT_ZERO;
                end
            endcase
        end
    end

    // Strobe is high exactly in the clamp phase.
    assign win_o = (phase == PH_CLAMP);

    AST_ZERO_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && width_i == CNT_ZERO && settle_i == CNT_ZERO) |=> !win_o); // R3
    AST_NO_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && settle_i == CNT_ZERO && width_i != CNT_ZERO) |=> win_o); // R2
    AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SETTLE && cnt != CNT_ZERO && !start_i) |=> !win_o); // R2
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && settle_i != CNT_ZERO) |=> !win_o); // R4

endmodule

// File: rtl/clamp_target_sel.sv
// Module: clamp_target_sel
// Captures the per-channel ground/midscale select at each trailing edge and
// produces the matching target code per lane. Assumes start is one cycle.
module clamp_target_sel #(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned CODE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [NUM_CH-1:0]        sel_i,
    output logic [NUM_CH-1:0]        mid_o,
    output logic [NUM_CH*CODE_W-1:0] code_o
);

    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] GND_CODE = '0;

    logic [NUM_CH-1:0] mid_q;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        // Per-channel select latch, loaded only at a trailing edge.
        always_ff @(posedge clk) begin
            if (!rst_n)       mid_q[ch] <= 1'b0;
            else if (start_i) mid_q[ch] <= sel_i[ch];
        end
        // Lane code from the latched select.
        assign code_o[ch*CODE_W +: CODE_W] = mid_q[ch] ? MID_CODE : GND_CODE;
    end

    assign mid_o = mid_q;

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(start_i)) |-> $stable(mid_q)); // R5

endmodule

// File: rtl/clamp_pulse_gen.sv
// Module: clamp_pulse_gen (top)
// Per-line clamp strobe for a three-channel digitizer: internal window timed
// from the sync trailing edge, or the polarity-corrected external clamp input.
// Assumes all inputs are synchronous to the pixel clock.
module clamp_pulse_gen #(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned CODE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hsync_in,
    input  logic                     ext_clamp_in,
    input  logic [CNT_W-1:0]         cfg_settle,
    input  logic [CNT_W-1:0]         cfg_width,
    input  logic                     cfg_ext_mode,
    input  logic                     cfg_ext_pol,
    input  logic                     cfg_sync_pol,
    input  logic [NUM_CH-1:0]        cfg_mid_sel,
    output logic                     clamp_o,
    output logic [NUM_CH-1:0]        tgt_mid_o,
    output logic [NUM_CH*CODE_W-1:0] tgt_code_o
);

    logic trail;
    logic win;
    logic ext_act;
    logic ext_q;
    logic mode_q;

    clamp_sync_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (hsync_in),
        .sync_pol (cfg_sync_pol),
        .trail_o  (trail)
    );

    clamp_window_fsm #(.CNT_W(CNT_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (trail),
        .settle_i (cfg_settle),
        .width_i  (cfg_width),
        .win_o    (win)
    );

    clamp_target_sel #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_tgt (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (trail),
        .sel_i   (cfg_mid_sel),
        .mid_o   (tgt_mid_o),
        .code_o  (tgt_code_o)
    );

    // External input polarity correction: pol=1 means active high.
    assign ext_act = cfg_ext_pol ? ext_clamp_in : ~ext_clamp_in;

    // Register external request and mode so both strobe sources leave flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q  <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            ext_q  <= ext_act;
            mode_q <= cfg_ext_mode;
        end
    end

    // Strobe source select.
    assign clamp_o = mode_q ? ext_q : win;

    AST_EXT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_ext_mode))
            |-> (clamp_o == ($past(ext_clamp_in) ~^ $past(cfg_ext_pol)))); // R6

endmodule

// File: tb/sim_clamp_pulse_gen.sv
`timescale 1ns/1ps
module sim_clamp_pulse_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync_in = 1'b0;
    logic        ext_clamp_in = 1'b0;
    logic [7:0]  cfg_settle = 8'd9;
    logic [7:0]  cfg_width = 8'd20;
    logic        cfg_ext_mode = 1'b0;
    logic        cfg_ext_pol = 1'b1;
    logic        cfg_sync_pol = 1'b0;
    logic [2:0]  cfg_mid_sel = 3'b000;
    logic        clamp_o;
    logic [2:0]  tgt_mid_o;
    logic [23:0] tgt_code_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    string tag = "R8";

    // bench model state
    bit m_prev = 0;
    bit m_run = 0;
    int m_k = 0;
    int m_p = 0;
    int m_d = 0;
    bit [2:0] m_sel = 0;
    bit m_mode = 0;
    bit m_ext = 0;

    always #2.5 clk = ~clk;

    clamp_pulse_gen u0 (
        .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .ext_clamp_in(ext_clamp_in),
        .cfg_settle(cfg_settle), .cfg_width(cfg_width), .cfg_ext_mode(cfg_ext_mode),
        .cfg_ext_pol(cfg_ext_pol), .cfg_sync_pol(cfg_sync_pol), .cfg_mid_sel(cfg_mid_sel),
        .clamp_o(clamp_o), .tgt_mid_o(tgt_mid_o), .tgt_code_o(tgt_code_o)
    );

    function automatic logic [23:0] code_of(input bit [2:0] s);
        code_of = {s[2] ? 8'h80 : 8'h00, s[1] ? 8'h80 : 8'h00, s[0] ? 8'h80 : 8'h00};
    endfunction

    function automatic bit exp_clamp();
        bit win;
        win = m_run && (m_k >= m_p) && (m_k < m_p + m_d);
        exp_clamp = m_mode ? m_ext : win;
    endfunction

    task automatic check(input string what, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One clock: update model at the edge, compare outputs 1 ns later.
    task automatic tick();
        bit act;
        @(posedge clk);
        if (!rst_n) begin
            m_prev = 0; m_run = 0; m_k = 0; m_sel = 0; m_mode = 0; m_ext = 0;
        end else begin
            act = hsync_in ^ cfg_sync_pol;
            if (m_prev && !act) begin
                m_run = 1; m_k = 0; m_p = cfg_settle; m_d = cfg_width; m_sel = cfg_mid_sel;
            end else if (m_run) begin
                m_k++;
                if (m_k > 1000) m_run = 0;
            end
            m_prev = act;
            m_mode = cfg_ext_mode;
            m_ext  = cfg_ext_pol ? ext_clamp_in : ~ext_clamp_in;
        end
        #1;
        check("clamp_o", {23'd0, clamp_o}, {23'd0, exp_clamp()});
        check("tgt_mid_o", {21'd0, tgt_mid_o}, {21'd0, m_sel});
        check("tgt_code_o", tgt_code_o, code_of(m_sel));
    endtask

    // One line: sync active for w cycles, inactive for g cycles;
    // optionally new settings are applied chg cycles into the gap.
    task automatic line(input int w, input int g, input int chg,
                        input bit [7:0] np, input bit [7:0] nd, input bit [2:0] ns);
        for (int i = 0; i < w; i++) begin
            hsync_in = 1'b1 ^ cfg_sync_pol;
            tick();
        end
        for (int i = 0; i < g; i++) begin
            hsync_in = 1'b0 ^ cfg_sync_pol;
            if (i == chg) begin
                cfg_settle = np; cfg_width = nd; cfg_mid_sel = ns;
            end
            tick();
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5a5a));
        // R8: reset state
        tag = "R8";
        hsync_in = 1'b1; ext_clamp_in = 1'b1; cfg_mid_sel = 3'b111;
        for (int i = 0; i < 4; i++) tick();
        #1 rst_n = 1'b1;
        hsync_in = 1'b0; cfg_mid_sel = 3'b000;
        for (int i = 0; i < 3; i++) tick();

        // R2: recommended defaults, then zero settle, then long counts
        tag = "R2";
        cfg_settle = clamp_pkg::SETTLE_DEFAULT[7:0]; cfg_width = clamp_pkg::WIDTH_DEFAULT[7:0];
        line(4, 40, -1, 0, 0, 0);
        cfg_settle = 8'd0; cfg_width = 8'd1;
        line(3, 10, -1, 0, 0, 0);
        cfg_settle = 8'd255; cfg_width = 8'd255;
        line(2, 520, -1, 0, 0, 0);

        // R3: zero strobe length
        tag = "R3";
        cfg_settle = 8'd5; cfg_width = 8'd0;
        line(3, 20, -1, 0, 0, 0);
        cfg_settle = 8'd0;
        line(3, 10, -1, 0, 0, 0);

        // R4: restart during settle, then during strobe
        tag = "R4";
        cfg_settle = 8'd10; cfg_width = 8'd10;
        line(2, 6, -1, 0, 0, 0);
        line(2, 14, -1, 0, 0, 0);
        line(2, 30, -1, 0, 0, 0);

        // R5: settings changed inside a running line
        tag = "R5";
        cfg_settle = 8'd6; cfg_width = 8'd8; cfg_mid_sel = 3'b101;
        line(2, 30, 3, 8'd1, 8'd2, 3'b010);
        line(2, 30, 9, 8'd20, 8'd0, 3'b111);
        line(2, 40, -1, 0, 0, 0);

        // R1: active-low sync
        tag = "R1";
        cfg_sync_pol = 1'b1; cfg_settle = 8'd3; cfg_width = 8'd4;
        hsync_in = 1'b1; tick();
        line(5, 15, -1, 0, 0, 0);
        line(1, 15, -1, 0, 0, 0);
        cfg_sync_pol = 1'b0; hsync_in = 1'b0; tick();

        // R6: external mode, both polarities, with sync still running
        tag = "R6";
        cfg_ext_mode = 1'b1;
        for (int pol = 0; pol < 2; pol++) begin
            cfg_ext_pol = pol[0];
            for (int i = 0; i < 40; i++) begin
                ext_clamp_in = $urandom_range(0, 1);
                hsync_in = (i % 13) < 2;
                tick();
            end
        end
        cfg_ext_mode = 1'b0; hsync_in = 1'b0; tick();

        // R7: every select pattern
        tag = "R7";
        cfg_settle = 8'd2; cfg_width = 8'd3;
        for (int s = 0; s < 8; s++) begin
            cfg_mid_sel = s[2:0];
            line(2, 8, -1, 0, 0, 0);
        end

        // Random lines mixing all behaviours
        tag = "R4 random";
        for (int n = 0; n < 60; n++) begin
            cfg_settle = 8'($urandom_range(0, 24));
            cfg_width = 8'($urandom_range(0, 24));
            cfg_mid_sel = 3'($urandom_range(0, 7));
            cfg_ext_mode = ($urandom_range(0, 5) == 0);
            cfg_ext_pol = $urandom_range(0, 1);
            ext_clamp_in = $urandom_range(0, 1);
            line($urandom_range(1, 6), $urandom_range(3, 70), $urandom_range(0, 40),
                 8'($urandom_range(0, 30)), 8'($urandom_range(0, 30)), 3'($urandom_range(0, 7)));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule